// File: doc/BRIEF.md
# Register-Directed Shift and Rotate Unit

This block is the shift and rotate stage of a small RISC integer pipeline. Each request carries a 32-bit operand, a 32-bit shift-control value taken from a register, a 4-bit opcode and the current T (carry/condition) flag. The block returns the shifted or rotated operand, the new T value and a strobe that tells the pipeline whether T is to be written back.

There are three groups of operations. Dynamic shifts take their direction from the sign of the control value and their distance from its low five bits, and a negative control value with a zero low field has a special meaning. One-bit shifts and rotates move a bit into T, and the rotate-through forms also feed the old T back into the word. Fixed logical shifts by 2, 8 and 16 leave T alone. The arithmetic is a purely combinational path. A parameter selects whether an output register sits behind it. With the register (the default), a result appears one clock after the request and `outValid` follows `inValid` with the same one-cycle delay.

Top module: `shift_rotate_unit`

## Requirements
- R1: Opcodes 0 (dynamic arithmetic) and 1 (dynamic logical). When bit 31 of `shiftCtl` is 0, the result is `operand` shifted left by `shiftCtl[4:0]`, with zeros entering at bit 0.
- R2: Opcodes 0 and 1 with bit 31 of `shiftCtl` set and `shiftCtl[4:0]` zero. Opcode 0 gives 32 copies of operand bit 31. Opcode 1 gives zero.
- R3: Opcodes 0 and 1 with bit 31 of `shiftCtl` set and `shiftCtl[4:0]` = n, where n is non-zero. The operand moves right by 32 - n places, which equals the bitwise-NOT of n plus one in five bits. Opcode 0 fills with the sign bit and opcode 1 fills with zeros.
- R4: Opcode 2 rotates left by one, and old bit 31 goes to both bit 0 and T. Opcode 3 rotates right by one, and old bit 0 goes to both bit 31 and T.
- R5: Opcode 4 shifts left by one, puts the incoming T at bit 0 and sets T to old bit 31. Opcode 5 shifts right by one, puts the incoming T at bit 31 and sets T to old bit 0.
- R6: Opcode 6 shifts left by one with a zero fill and sets T to old bit 31. Opcode 7 shifts right by one with a zero fill and sets T to old bit 0. Opcode 8 is the same as 7 except that bit 31 keeps its old value.
- R7: Opcodes 9 to 14 are logical shifts with zero fill: 9 left by 2, 10 right by 2, 11 left by 8, 12 right by 8, 13 left by 16, 14 right by 16.
- R8: `tWe` is 1 for opcodes 2 to 8 only. Whenever `tWe` is 0, `tOut` equals the incoming `tIn`.
- R9: Opcode 15 returns the operand unchanged with `tWe` at 0.
- R10: With the output register in place, `result`, `tOut` and `tWe` reflect the request presented one clock earlier, and `outValid` equals `inValid` from one clock earlier. While `rstN` is low, `outValid`, `result`, `tOut` and `tWe` are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request present this cycle |
| opcode | input | 4 | Operation select (see R1 to R9) |
| operand | input | 32 | Word to shift or rotate |
| shiftCtl | input | 32 | Signed control value for dynamic shifts |
| tIn | input | 1 | Current T flag |
| outValid | output | 1 | Result valid |
| result | output | 32 | Shifted or rotated word |
| tOut | output | 1 | New T flag value |
| tWe | output | 1 | T write-back strobe |

## Verification
The dynamic shifts have the most edge cases. These occur when the control value is negative and its low field is 0, 1 or 31: the first falls back to sign fill or zero, the second moves the operand right by 31, and the third moves it right by one. These cases only show up when the sign bit and the low field are chosen on purpose. The directed part of the stimulus therefore sweeps every opcode against those three low fields in both signs, using operands with and without bit 31 set. The random part varies the middle control bits to show that they are ignored.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [3:0] {
    OP_SHA_DYN = 4'd0,
    OP_SHL_DYN = 4'd1,
    OP_ROL     = 4'd2,
    OP_ROR     = 4'd3,
    OP_ROLT    = 4'd4,
    OP_RORT    = 4'd5,
    OP_SHL1    = 4'd6,
    OP_SHR1    = 4'd7,
    OP_SAR1    = 4'd8,
    OP_SHL2    = 4'd9,
    OP_SHR2    = 4'd10,
    OP_SHL8    = 4'd11,
    OP_SHR8    = 4'd12,
    OP_SHL16   = 4'd13,
    OP_SHR16   = 4'd14,
    OP_PASS    = 4'd15
  } sruOp_e;

  typedef enum logic [1:0] {
    K_PASS  = 2'd0,
    K_DYN   = 2'd1,
    K_ONE   = 2'd2,
    K_FIXED = 2'd3
  } sruKind_e;

  typedef enum logic [1:0] {
    INS_ZERO = 2'd0,
    INS_WRAP = 2'd1,
    INS_T    = 2'd2,
    INS_SIGN = 2'd3
  } sruIns_e;

  typedef struct packed {
    sruKind_e   kind;
    logic       goRight;
    logic       arith;
    sruIns_e    insSel;
    logic [4:0] fixAmt;
    logic       tWrite;
  } sruStrobe_t;

endpackage

// File: rtl/sru_control.sv
module sru_control
  import sru_pkg::*;
(
  input  logic [3:0] opcode,
  output sruStrobe_t strobe
);

  always_comb begin
    strobe = '{kind: K_PASS, goRight: 1'b0, arith: 1'b0,
               insSel: INS_ZERO, fixAmt: 5'd0, tWrite: 1'b0};
    case (sruOp_e'(opcode))
      OP_SHA_DYN: begin strobe.kind = K_DYN; strobe.arith = 1'b1; end
      OP_SHL_DYN: begin strobe.kind = K_DYN; end
      OP_ROL: begin
        strobe.kind = K_ONE; strobe.insSel = INS_WRAP; strobe.tWrite = 1'b1;
      end
      OP_ROR: begin
        strobe.kind = K_ONE; strobe.insSel = INS_WRAP; strobe.goRight = 1'b1;
        strobe.tWrite = 1'b1;
      end
      OP_ROLT: begin
        strobe.kind = K_ONE; strobe.insSel = INS_T; strobe.tWrite = 1'b1;
      end
      OP_RORT: begin
        strobe.kind = K_ONE; strobe.insSel = INS_T; strobe.goRight = 1'b1;
        strobe.tWrite = 1'b1;
      end
      OP_SHL1: begin strobe.kind = K_ONE; strobe.tWrite = 1'b1; end
      OP_SHR1: begin
        strobe.kind = K_ONE; strobe.goRight = 1'b1; strobe.tWrite = 1'b1;
      end
      OP_SAR1: begin
        strobe.kind = K_ONE; strobe.goRight = 1'b1; strobe.insSel = INS_SIGN;
        strobe.tWrite = 1'b1;
      end
      OP_SHL2:  begin strobe.kind = K_FIXED; strobe.fixAmt = 5'd2; end
      OP_SHR2:  begin strobe.kind = K_FIXED; strobe.fixAmt = 5'd2;  strobe.goRight = 1'b1; end
      OP_SHL8:  begin strobe.kind = K_FIXED; strobe.fixAmt = 5'd8; end
      OP_SHR8:  begin strobe.kind = K_FIXED; strobe.fixAmt = 5'd8;  strobe.goRight = 1'b1; end
      OP_SHL16: begin strobe.kind = K_FIXED; strobe.fixAmt = 5'd16; end
      OP_SHR16: begin strobe.kind = K_FIXED; strobe.fixAmt = 5'd16; strobe.goRight = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/sru_datapath.sv
module sru_datapath
  import sru_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  sruStrobe_t        strobe,
  input  logic [DATA_W-1:0] operand,
  input  logic              ctlNeg,
  input  logic [SH_W-1:0]   ctlMag,
  input  logic              tIn,
  output logic [DATA_W-1:0] resNext,
  output logic              tNext
);

  localparam int MSB = DATA_W - 1;

  logic [SH_W-1:0] revAmt;
  logic            insBit;
  logic [DATA_W-1:0] dynRes, oneRes, fixRes;

  assign revAmt = (~ctlMag) + SH_W'(1);

  // dynamic shift: sign of control picks direction
  always_comb begin
    if (!ctlNeg)
      dynRes = operand << ctlMag;
    else if (ctlMag == '0)
      dynRes = strobe.arith ? {DATA_W{operand[MSB]}} : '0;
    else if (strobe.arith)
      dynRes = $unsigned($signed(operand) >>> revAmt);
    else
      dynRes = operand >> revAmt;
  end

  // one-bit forms: pick the bit that enters at the vacated end
  always_comb begin
    case (strobe.insSel)
      INS_WRAP: insBit = strobe.goRight ? operand[0] : operand[MSB];
      INS_T:    insBit = tIn;
      INS_SIGN: insBit = operand[MSB];
      default:  insBit = 1'b0;
    endcase
    oneRes = strobe.goRight ? {insBit, operand[MSB:1]}
                            : {operand[MSB-1:0], insBit};
  end

  assign fixRes = strobe.goRight ? (operand >> strobe.fixAmt)
                                 : (operand << strobe.fixAmt);

  always_comb begin
    tNext = tIn;
    case (strobe.kind)
      K_DYN:   resNext = dynRes;
      K_ONE: begin
        resNext = oneRes;
        tNext   = strobe.goRight ? operand[0] : operand[MSB];
      end
      K_FIXED: resNext = fixRes;
      default: resNext = operand;
    endcase
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] shiftCtl,
  input  logic              tIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              tOut,
  output logic              tWe
);

  localparam int SH_W = $clog2(DATA_W);

  sruStrobe_t        strobe;
  logic [DATA_W-1:0] resNext;
  logic              tNext;

  sru_control uCtl (
    .opcode (opcode),
    .strobe (strobe)
  );

  sru_datapath #(.DATA_W(DATA_W)) uDp (
    .strobe  (strobe),
    .operand (operand),
    .ctlNeg  (shiftCtl[DATA_W-1]),
    .ctlMag  (shiftCtl[SH_W-1:0]),
    .tIn     (tIn),
    .resNext (resNext),
    .tNext   (tNext)
  );

  generate
    if (OUT_REG) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outValid <= 1'b0;
          result   <= '0;
          tOut     <= 1'b0;
          tWe      <= 1'b0;
        end else begin
          outValid <= inValid;
          result   <= resNext;
          tOut     <= tNext;
          tWe      <= strobe.tWrite;
        end
      end
    end else begin : gComb
      assign outValid = inValid;
      assign result   = resNext;
      assign tOut     = tNext;
      assign tWe      = strobe.tWrite;
    end
  endgenerate

endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [3:0]        opcode,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] shiftCtl,
  input logic              tIn,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              tOut,
  input logic              tWe
);

  localparam int MSB = DATA_W - 1;

  generate
    if (OUT_REG) begin : gChk
      AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
        outValid == $past(inValid)); // R10

      AST_T_HELD: assert property (@(posedge clk) disable iff (!rstN)
        !tWe |-> tOut == $past(tIn)); // R8

      AST_ROTATE_LEFT: assert property (@(posedge clk) disable iff (!rstN)
        opcode == 4'd2 |=> result == {$past(operand[MSB-1:0]), $past(operand[MSB])}
                           && tOut == $past(operand[MSB]) && tWe); // R4

      AST_NEG_ZERO_LOGIC: assert property (@(posedge clk) disable iff (!rstN)
        (opcode == 4'd1 && shiftCtl[MSB] && shiftCtl[4:0] == 5'd0) |=> result == '0); // R2

      AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
        opcode == 4'd15 |=> result == $past(operand) && !tWe); // R9

      AST_FIXED_NO_T: assert property (@(posedge clk) disable iff (!rstN)
        (opcode >= 4'd9 && opcode <= 4'd14) |=> !tWe); // R7
    end
  endgenerate

endmodule

bind shift_rotate_unit sru_checker #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) uChk (.*);

// File: tb/sim_shift_rotate_unit.sv
module sim_shift_rotate_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opcode = 4'd0;
  logic [31:0] operand = '0;
  logic [31:0] shiftCtl = '0;
  logic        tIn = 1'b0;
  logic        outValid;
  logic [31:0] result;
  logic        tOut;
  logic        tWe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  shift_rotate_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .operand(operand), .shiftCtl(shiftCtl), .tIn(tIn),
    .outValid(outValid), .result(result), .tOut(tOut), .tWe(tWe)
  );

  function automatic string reqOf(input logic [3:0] op, input logic [31:0] c);
    if (op <= 4'd1) return !c[31] ? "R1" : (c[4:0] == 5'd0 ? "R2" : "R3");
    if (op <= 4'd3) return "R4";
    if (op <= 4'd5) return "R5";
    if (op <= 4'd8) return "R6";
    if (op <= 4'd14) return "R7";
    return "R9";
  endfunction

  // returns {writeT, newT, word}
  function automatic logic [33:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] c, input logic t);
    logic [31:0] r;
    logic nt, we;
    int n;
    r = a; nt = t; we = 1'b0;
    case (op)
      4'd0, 4'd1: begin
        if (c[31] == 1'b0) r = a << c[4:0];
        else if (c[4:0] == 5'd0) r = (op == 4'd0 && a[31]) ? 32'hFFFF_FFFF : 32'h0;
        else begin
          n = 32 - int'(c[4:0]);
          r = a >> n;
          if (op == 4'd0 && a[31]) r = r | ~(32'hFFFF_FFFF >> n);
        end
      end
      4'd2: begin r = {a[30:0], a[31]}; nt = a[31]; we = 1'b1; end
      4'd3: begin r = {a[0], a[31:1]}; nt = a[0]; we = 1'b1; end
      4'd4: begin r = {a[30:0], t}; nt = a[31]; we = 1'b1; end
      4'd5: begin r = {t, a[31:1]}; nt = a[0]; we = 1'b1; end
      4'd6: begin r = {a[30:0], 1'b0}; nt = a[31]; we = 1'b1; end
      4'd7: begin r = {1'b0, a[31:1]}; nt = a[0]; we = 1'b1; end
      4'd8: begin r = {a[31], a[31:1]}; nt = a[0]; we = 1'b1; end
      4'd9:  r = a << 2;
      4'd10: r = a >> 2;
      4'd11: r = a << 8;
      4'd12: r = a >> 8;
      4'd13: r = a << 16;
      4'd14: r = a >> 16;
      default: r = a;
    endcase
    return {we, nt, r};
  endfunction

  // drive at a falling edge, compare at the next falling edge (one register)
  task automatic runOne(input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] c, input logic t);
    logic [33:0] exp;
    string rq;
    exp = model(op, a, c, t);
    rq = reqOf(op, c);
    inValid = 1'b1; opcode = op; operand = a; shiftCtl = c; tIn = t;
    @(negedge clk);
    checks++;
    if (result !== exp[31:0] || tOut !== exp[32] || tWe !== exp[33] || outValid !== 1'b1) begin
      fails++;
      $display("FAIL %s/R8/R10 op=%0d a=%h c=%h t=%b: got r=%h t=%b we=%b v=%b exp r=%h t=%b we=%b v=1",
               rq, op, a, c, t, result, tOut, tWe, outValid, exp[31:0], exp[32], exp[33]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] ops[4];
    logic [4:0]  lows[3];
    int unsigned seed;
    ops[0] = 32'h8000_0001; ops[1] = 32'h7FFF_FFFE;
    ops[2] = 32'hA5C3_0F96; ops[3] = 32'h1234_5678;
    lows[0] = 5'd0; lows[1] = 5'd1; lows[2] = 5'd31;
    seed = 32'd12345;
    void'($urandom(seed));

    // R10 reset state
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || result !== '0 || tOut !== 1'b0 || tWe !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: got v=%b r=%h t=%b we=%b exp all zero", outValid, result, tOut, tWe);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R10 valid follows inValid: idle cycle
    inValid = 1'b0;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R10 idle valid: got %b exp 0", outValid);
    end

    // directed sweep: all opcodes, low fields 0/1/31, both signs, both T
    for (int op = 0; op < 16; op++)
      for (int oi = 0; oi < 4; oi++)
        for (int li = 0; li < 3; li++)
          for (int s = 0; s < 2; s++)
            for (int t = 0; t < 2; t++)
              runOne(4'(op), ops[oi], {s[0], 26'h155_5555 ^ 26'(oi), lows[li]}, t[0]);

    // random: middle control bits are ignored by R1..R3
    for (int k = 0; k < 3000; k++)
      runOne(4'($urandom % 16), $urandom, $urandom, 1'($urandom % 2));

    // R10 valid drops one cycle after inValid drops
    inValid = 1'b0;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R10 valid drop: got %b exp 0", outValid);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule